// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block holds a small set of recent page translations for a processor's memory pipeline. Each stored entry maps a virtual page number to a physical frame number. The entry also carries the identifier of the address space that owns it, a global flag, a write permission and a modified flag. A requester presents a virtual page number, the current address-space identifier and a read/write flag. Every entry is compared at once, and the answer comes back combinationally in the same cycle. The answer is one of four outcomes: a hit, a miss, a permission fault on a write, or an update request when a write reaches a clean page.

A page walker that sits outside this block installs translations through a fill port. The block picks the slot for each fill. It reuses an entry that already holds the same key. Failing that, it takes the lowest empty slot. When every slot is full, it evicts the slot named by a rotating pointer.

A flush port supports both ways of keeping processes apart. A context switch can wipe every entry, or it can drop only the non-global entries of one address space. Flushes and fills are applied at the clock edge, so a lookup made in the same cycle still sees the older contents.

Top module: `tlb_asid_cache`

## Requirements
- R1: After reset every entry is invalid, so every lookup reports a miss until a fill is made.
- R2: While `lk_valid` is high, exactly one of `lk_hit`, `lk_miss`, `lk_upd`, `lk_perm` is high in the same cycle. While `lk_valid` is low, all four are low.
- R3: An entry matches when it is valid, its page number equals `lk_vpn`, and either its address-space tag equals `lk_asid` or its global flag is set. On a match, `lk_pfn` carries that entry's frame number.
- R4: Entries with the same page number but different address-space tags coexist, and each one answers only to its own tag.
- R5: A write that matches an entry without write permission raises `lk_perm`. A write that matches a writable entry whose modified flag is clear raises `lk_upd`. In both cases `lk_pfn` carries the frame number.
- R6: A fill goes to the entry that already matches its key if there is one. Otherwise it goes to the lowest-numbered invalid entry. Otherwise it evicts the entry named by a rotating pointer. That pointer starts at 0 after reset, moves up by one only on an eviction, and wraps after the last entry.
- R7: `flush_all` makes every entry invalid from the next cycle.
- R8: `flush_asid_en` invalidates, from the next cycle, the entries whose tag equals `flush_asid` and whose global flag is clear. Entries of other address spaces and global entries stay.
- R9: A lookup made in the same cycle as a flush answers from the contents held before that flush.
- R10: A fill presented in the same cycle as either kind of flush is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asid | input | ASID_W | Current address-space identifier |
| lk_write | input | 1 | Lookup is for a store |
| lk_hit | output | 1 | Translation usable as is |
| lk_miss | output | 1 | No matching entry |
| lk_upd | output | 1 | Write to a clean page; the walker must set the modified flag |
| lk_perm | output | 1 | Write to a page without write permission |
| lk_pfn | output | PFN_W | Frame number of the matching entry |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Page number to install |
| fill_asid | input | ASID_W | Owning address space |
| fill_pfn | input | PFN_W | Frame number to install |
| fill_writable | input | 1 | Write permission of the page |
| fill_dirty | input | 1 | Modified flag of the page |
| fill_global | input | 1 | Entry matches every address space |
| flush_all | input | 1 | Invalidate every entry |
| flush_asid_en | input | 1 | Invalidate the non-global entries of one address space |
| flush_asid | input | ASID_W | Address space to flush |

## Verification
The assertions check the following on every cycle:
- the response is one-hot, and silent while idle;
- permission and update outcomes appear only on writes;
- an empty array follows reset and a global flush;
- the chosen victim slot becomes valid after a fill;
- the rotating pointer steps on evictions;
- no entry becomes valid in a flush cycle.

Some behaviour needs the bench's ordered scenarios. These are the frame numbers returned for coexisting address spaces, the overwrite of an existing key, the choice of lowest empty slot versus eviction over a long fill sequence, the survival of global entries across an address-space flush, and the old contents seen by a lookup in a flush cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    RSP_MISS = 2'd0,
    RSP_HIT  = 2'd1,
    RSP_UPD  = 2'd2,
    RSP_PERM = 2'd3
  } tlb_rsp_e;

  // Outcome of a lookup from the match summary and the selected entry flags.
  function automatic tlb_rsp_e classify(input logic any_match, input logic is_write,
                                        input logic writable, input logic dirty);
    if (!any_match)     return RSP_MISS;
    else if (!is_write) return RSP_HIT;
    else if (!writable) return RSP_PERM;
    else if (!dirty)    return RSP_UPD;
    else                return RSP_HIT;
  endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N      = 8,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic [N-1:0]      ent_valid,
  input  logic [N-1:0]      ent_global,
  input  logic [VPN_W-1:0]  ent_vpn  [N],
  input  logic [ASID_W-1:0] ent_asid [N],
  input  logic [VPN_W-1:0]  key_vpn,
  input  logic [ASID_W-1:0] key_asid,
  output logic [N-1:0]      match_vec
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match_vec[i] = ent_valid[i] && (ent_vpn[i] == key_vpn) &&
                          (ent_global[i] || (ent_asid[i] == key_asid));
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     ent_valid,
  input  logic [N-1:0]     same_key,
  input  logic [IDX_W-1:0] rr_ptr,
  output logic [IDX_W-1:0] victim_idx,
  output logic             victim_evict
);
  function automatic logic [IDX_W-1:0] lowest_one(input logic [N-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  always_comb begin
    victim_evict = 1'b0;
    if (|same_key) begin
      victim_idx = lowest_one(same_key);
    end else if (|(~ent_valid)) begin
      victim_idx = lowest_one(~ent_valid);
    end else begin
      victim_idx   = rr_ptr;
      victim_evict = 1'b1;
    end
  end
endmodule

// File: rtl/tlb_asid_cache.sv
module tlb_asid_cache #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 16,
  parameter int ASID_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_write,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic              lk_upd,
  output logic              lk_perm,
  output logic [PFN_W-1:0]  lk_pfn,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic              fill_writable,
  input  logic              fill_dirty,
  input  logic              fill_global,
  input  logic              flush_all,
  input  logic              flush_asid_en,
  input  logic [ASID_W-1:0] flush_asid
);
  import tlb_pkg::*;

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] v_q, g_q, w_q, d_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  logic [IDX_W-1:0]   rr_q;

  // Named internal events
  logic [ENTRIES-1:0] lk_vec, fill_vec;
  logic [IDX_W-1:0]   lk_sel, victim_idx;
  logic               victim_evict, any_flush, fill_we;
  tlb_rsp_e           rsp;

  assign any_flush = flush_all || flush_asid_en;
  assign fill_we   = fill_valid && !any_flush;

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
    .ent_valid(v_q), .ent_global(g_q), .ent_vpn(vpn_q), .ent_asid(asid_q),
    .key_vpn(lk_vpn), .key_asid(lk_asid), .match_vec(lk_vec)
  );

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fill_match (
    .ent_valid(v_q), .ent_global(g_q), .ent_vpn(vpn_q), .ent_asid(asid_q),
    .key_vpn(fill_vpn), .key_asid(fill_asid), .match_vec(fill_vec)
  );

  tlb_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .ent_valid(v_q), .same_key(fill_vec), .rr_ptr(rr_q),
    .victim_idx(victim_idx), .victim_evict(victim_evict)
  );

  // Lowest matching entry drives the answer.
  always_comb begin
    lk_sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lk_vec[i]) lk_sel = IDX_W'(i);
    end
  end

  assign rsp     = classify(|lk_vec, lk_write, w_q[lk_sel], d_q[lk_sel]);
  assign lk_hit  = lk_valid && (rsp == RSP_HIT);
  assign lk_miss = lk_valid && (rsp == RSP_MISS);
  assign lk_upd  = lk_valid && (rsp == RSP_UPD);
  assign lk_perm = lk_valid && (rsp == RSP_PERM);
  assign lk_pfn  = pfn_q[lk_sel];

  // Valid bits and replacement pointer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q  <= '0;
      rr_q <= '0;
    end else if (flush_all) begin
      v_q <= '0;
    end else if (flush_asid_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (!g_q[i] && (asid_q[i] == flush_asid)) v_q[i] <= 1'b0;
      end
    end else if (fill_valid) begin
      v_q[victim_idx] <= 1'b1;
      if (victim_evict) rr_q <= (rr_q == LAST_IDX) ? '0 : rr_q + 1'b1;
    end
  end

  // Entry payload, written only by accepted fills
  always_ff @(posedge clk) begin
    if (fill_we) begin
      vpn_q[victim_idx]  <= fill_vpn;
      asid_q[victim_idx] <= fill_asid;
      pfn_q[victim_idx]  <= fill_pfn;
      g_q[victim_idx]    <= fill_global;
      w_q[victim_idx]    <= fill_writable;
      d_q[victim_idx]    <= fill_dirty;
    end
  end

endmodule

// File: rtl/tlb_asid_cache_chk.sv
module tlb_asid_cache_chk #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             lk_write,
  input logic             lk_hit,
  input logic             lk_miss,
  input logic             lk_upd,
  input logic             lk_perm,
  input logic             fill_valid,
  input logic             flush_all,
  input logic             flush_asid_en,
  input logic [N-1:0]     valid_q,
  input logic [IDX_W-1:0] victim_idx,
  input logic             victim_evict,
  input logic [IDX_W-1:0] rr_q
);
  logic             was_rst;
  logic [IDX_W-1:0] rr_next;

  always_ff @(posedge clk) was_rst <= !rst_n;
  assign rr_next = (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;

  always @(negedge clk) begin
    if (rst_n && was_rst) begin
      assert_reset_empty_R1: assert (valid_q == '0);
    end
  end

  assert_one_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $onehot({lk_hit, lk_miss, lk_upd, lk_perm}));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !(lk_hit || lk_miss || lk_upd || lk_perm));

  assert_write_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_upd || lk_perm) |-> lk_write);

  assert_fill_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !flush_all && !flush_asid_en) |=> valid_q[$past(victim_idx)]);

  assert_rr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !flush_all && !flush_asid_en && victim_evict) |=> (rr_q == $past(rr_next)));

  assert_flush_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_q == '0));

  assert_flush_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all || flush_asid_en) |=> ((valid_q & ~$past(valid_q)) == '0));

endmodule

bind tlb_asid_cache tlb_asid_cache_chk #(.N(ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_write(lk_write),
  .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_upd(lk_upd), .lk_perm(lk_perm),
  .fill_valid(fill_valid), .flush_all(flush_all), .flush_asid_en(flush_asid_en),
  .valid_q(v_q), .victim_idx(victim_idx), .victim_evict(victim_evict), .rr_q(rr_q)
);

// File: tb/tb_tlb_asid_cache.sv
module tb_tlb_asid_cache;
  localparam int CLK_PERIOD = 10;
  localparam int VPN_W = 20, PFN_W = 16, ASID_W = 8;
  // kinds: 0 miss, 1 hit, 2 update, 3 permission fault
  localparam int NV = 11;
  localparam logic [46:0] VEC [NV] = '{
    {20'h00010, 8'd1, 1'b0, 2'd1, 16'h00A1},  // R3
    {20'h00010, 8'd2, 1'b0, 2'd1, 16'h00E5},  // R4
    {20'h00010, 8'd3, 1'b0, 2'd0, 16'h0000},  // R4
    {20'h00020, 8'd1, 1'b1, 2'd2, 16'h00B2},  // R5
    {20'h00020, 8'd1, 1'b0, 2'd1, 16'h00B2},  // R3
    {20'h00030, 8'd2, 1'b1, 2'd3, 16'h00C3},  // R5
    {20'h00030, 8'd2, 1'b0, 2'd1, 16'h00C3},  // R3
    {20'h00040, 8'd9, 1'b0, 2'd1, 16'h00D4},  // R3 global
    {20'h00040, 8'd9, 1'b1, 2'd1, 16'h00D4},  // R3 global
    {20'h00050, 8'd1, 1'b0, 2'd0, 16'h0000},  // R3
    {20'h00010, 8'd1, 1'b1, 2'd1, 16'h00A1}   // R5 dirty write
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 1'b0, lk_write = 1'b0;
  logic [VPN_W-1:0] lk_vpn = '0, fill_vpn = '0;
  logic [ASID_W-1:0] lk_asid = '0, fill_asid = '0, flush_asid = '0;
  logic [PFN_W-1:0] fill_pfn = '0, lk_pfn;
  logic fill_valid = 1'b0, fill_writable = 1'b0, fill_dirty = 1'b0, fill_global = 1'b0;
  logic flush_all = 1'b0, flush_asid_en = 1'b0;
  logic lk_hit, lk_miss, lk_upd, lk_perm;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tlb_asid_cache dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .lk_write(lk_write), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_upd(lk_upd),
    .lk_perm(lk_perm), .lk_pfn(lk_pfn), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
    .fill_asid(fill_asid), .fill_pfn(fill_pfn), .fill_writable(fill_writable),
    .fill_dirty(fill_dirty), .fill_global(fill_global), .flush_all(flush_all),
    .flush_asid_en(flush_asid_en), .flush_asid(flush_asid)
  );

  function automatic logic [3:0] kind_bits(input int k);
    case (k)
      0: return 4'b0100;  // {hit, miss, upd, perm}
      1: return 4'b1000;
      2: return 4'b0010;
      default: return 4'b0001;
    endcase
  endfunction

  // Sample within the cycle, after the combinational answer settles.
  task automatic probe(input logic [VPN_W-1:0] vpn, input logic [ASID_W-1:0] asid,
                       input logic wr, input int kind, input logic [PFN_W-1:0] pfn,
                       input string req);
    logic [3:0] got;
    lk_valid = 1'b1; lk_vpn = vpn; lk_asid = asid; lk_write = wr;
    #1;
    got = {lk_hit, lk_miss, lk_upd, lk_perm};
    checks++;
    if (got !== kind_bits(kind) || (kind != 0 && lk_pfn !== pfn)) begin
      fails++;
      $display("FAIL %s vpn=%h asid=%0d: rsp=%b pfn=%h expected rsp=%b pfn=%h",
               req, vpn, asid, got, lk_pfn, kind_bits(kind), pfn);
    end
  endtask

  task automatic look(input logic [VPN_W-1:0] vpn, input logic [ASID_W-1:0] asid,
                      input logic wr, input int kind, input logic [PFN_W-1:0] pfn,
                      input string req);
    @(negedge clk);
    probe(vpn, asid, wr, kind, pfn, req);
  endtask

  task automatic fill(input logic [VPN_W-1:0] vpn, input logic [ASID_W-1:0] asid,
                      input logic [PFN_W-1:0] pfn, input logic wrt, input logic dty,
                      input logic glb);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_asid = asid; fill_pfn = pfn;
    fill_writable = wrt; fill_dirty = dty; fill_global = glb;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    look(20'h00010, 8'd1, 1'b0, 0, '0, "R1");
    look(20'h00000, 8'd0, 1'b0, 0, '0, "R1");
    @(negedge clk); lk_valid = 1'b0; #1;
    checks++;
    if ({lk_hit, lk_miss, lk_upd, lk_perm} !== 4'b0000) begin
      fails++;
      $display("FAIL R2 idle: rsp=%b expected 0000", {lk_hit, lk_miss, lk_upd, lk_perm});
    end

    fill(20'h00010, 8'd1, 16'h00A1, 1'b1, 1'b1, 1'b0);  // slot 0
    fill(20'h00020, 8'd1, 16'h00B2, 1'b1, 1'b0, 1'b0);  // slot 1
    fill(20'h00030, 8'd2, 16'h00C3, 1'b0, 1'b0, 1'b0);  // slot 2
    fill(20'h00040, 8'd5, 16'h00D4, 1'b1, 1'b1, 1'b1);  // slot 3 global
    fill(20'h00010, 8'd2, 16'h00E5, 1'b1, 1'b1, 1'b0);  // slot 4

    for (int i = 0; i < NV; i++) begin
      look(VEC[i][46:27], VEC[i][26:19], VEC[i][18], int'(VEC[i][17:16]), VEC[i][15:0],
           "R2/R3/R4/R5 table");
    end

    // R6 overwrite of existing key, then fill remaining slots and evict
    fill(20'h00020, 8'd1, 16'h00BB, 1'b1, 1'b1, 1'b0);
    look(20'h00020, 8'd1, 1'b1, 1, 16'h00BB, "R6 overwrite");
    fill(20'h00060, 8'd1, 16'h0061, 1'b1, 1'b1, 1'b0);  // slot 5
    fill(20'h00070, 8'd1, 16'h0071, 1'b1, 1'b1, 1'b0);  // slot 6
    fill(20'h00080, 8'd1, 16'h0081, 1'b1, 1'b1, 1'b0);  // slot 7
    fill(20'h00090, 8'd1, 16'h0091, 1'b1, 1'b1, 1'b0);  // evicts slot 0
    look(20'h00010, 8'd1, 1'b0, 0, '0, "R6 evict slot0");
    look(20'h00010, 8'd2, 1'b0, 1, 16'h00E5, "R6 neighbour kept");
    fill(20'h000A0, 8'd1, 16'h00A0, 1'b1, 1'b1, 1'b0);  // evicts slot 1
    look(20'h00020, 8'd1, 1'b0, 0, '0, "R6 evict slot1");
    look(20'h00090, 8'd1, 1'b0, 1, 16'h0091, "R6 new entry");

    // R9 same-cycle lookup sees old contents; R8 address-space flush
    @(negedge clk);
    flush_asid_en = 1'b1; flush_asid = 8'd2;
    probe(20'h00030, 8'd2, 1'b0, 1, 16'h00C3, "R9 pre-flush view");
    @(negedge clk); flush_asid_en = 1'b0;
    probe(20'h00030, 8'd2, 1'b0, 0, '0, "R8 flushed");
    look(20'h00010, 8'd2, 1'b0, 0, '0, "R8 flushed");
    look(20'h00040, 8'd2, 1'b0, 1, 16'h00D4, "R8 global kept");
    look(20'h00060, 8'd1, 1'b0, 1, 16'h0061, "R8 other asid kept");

    // R6 refill lowest invalid slots without moving pointer (rr = 2)
    fill(20'h000B0, 8'd1, 16'h00B0, 1'b1, 1'b1, 1'b0);  // slot 2
    fill(20'h000C0, 8'd1, 16'h00C0, 1'b1, 1'b1, 1'b0);  // slot 4
    fill(20'h000D0, 8'd1, 16'h00D0, 1'b1, 1'b1, 1'b0);  // evicts slot 2
    look(20'h000B0, 8'd1, 1'b0, 0, '0, "R6 pointer held");
    look(20'h000C0, 8'd1, 1'b0, 1, 16'h00C0, "R6 pointer held");
    look(20'h000D0, 8'd1, 1'b0, 1, 16'h00D0, "R6 pointer held");

    // R7 global flush with a same-cycle fill (R10)
    @(negedge clk);
    flush_all = 1'b1;
    fill_valid = 1'b1; fill_vpn = 20'h000E0; fill_asid = 8'd1; fill_pfn = 16'h00E0;
    fill_writable = 1'b1; fill_dirty = 1'b1; fill_global = 1'b0;
    @(negedge clk);
    flush_all = 1'b0; fill_valid = 1'b0;
    probe(20'h000E0, 8'd1, 1'b0, 0, '0, "R10 fill dropped");
    look(20'h00040, 8'd5, 1'b0, 0, '0, "R7 global entry gone");
    look(20'h000D0, 8'd1, 1'b0, 0, '0, "R7 all gone");

    @(negedge clk);
    lk_valid = 1'b0;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule